// File: doc/BRIEF.md
# Debounced Ethernet Link State Qualifier

This block turns a stream of PHY status snapshots into a qualified link state. A poller elsewhere reads the PHY basic status word and a side status word at intervals, then presents them here with a one-cycle valid strobe. The block remembers the last status word and counts the clock cycles since it last changed. Each new snapshot goes through a fixed, ordered list of rules that yields UNKNOWN, DOWN or UP.

A status word that changes again and again within the settle window holds the verdict at UNKNOWN. In this way an up-down-up sequence during auto-negotiation becomes a single event. A fall from UP is taken at once. Only moves into or out of UP are reported. Each report gives a one-cycle pulse, latches speed and duplex, and increments one of two saturating event counters. While the state is UNKNOWN, a re-evaluation request tells the poller to send another snapshot even when nothing has changed.

Top module: `link_qualifier`

## Requirements
- R1: After reset the state is UNKNOWN (code 0), the stored status word is 0x0000, speed is none (code 0), duplex is unknown (code 0), both counters are 0 and the report pulse is low.
- R2: A sampled status word that differs from the stored one replaces it and restarts the since-change count. That sample sees an elapsed time of 0. A sample taken n cycles later, with the word unchanged, sees n.
- R3: The raw state is UP when status bit 2 is 1 and DOWN when it is 0.
- R4: A sampled status word of 0xFFFF gives DOWN, ahead of every other rule.
- R5: When the current state is UP and the raw state is DOWN, the new state is DOWN on that same sample, whatever the elapsed time.
- R6: If neither of the above applies and the elapsed time is below SETTLE_CYC, the new state is UNKNOWN.
- R7: Past the settle window, status bit 5 (auto-negotiation complete) set keeps the raw state. With bit 5 clear, the state is forced to DOWN if auto-negotiation is enabled; if it is not enabled, the raw state is kept.
- R8: A candidate UP becomes UNKNOWN unless the side link bit and the signal bit are both 1 and exactly one of the 10 Mb/s and 100 Mb/s bits is 1.
- R9: A state change is reported with a one-cycle pulse, on the cycle after the sample, only when the old or the new state is UP. Changes between DOWN and UNKNOWN, and samples that leave the state as it is, give no pulse.
- R10: A reported move into UP sets speed to 100 (code 2) if the side 100 Mb/s bit is 1 and to 10 (code 1) otherwise. It sets duplex to full (code 2) or half (code 1) from the side duplex bit. A reported move out of UP sets speed to none (0) and duplex to unknown (0).
- R11: A reported move into UP increments the up counter, and any other reported move increments the drop counter. Both counters hold at their maximum value.
- R12: The re-evaluation request is high exactly while the state is UNKNOWN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid_i | input | 1 | Snapshot strobe, one cycle per sample |
| status_i | input | 16 | PHY basic status word |
| side_link_i | input | 1 | Side status: link good |
| side_sig_i | input | 1 | Side status: signal present |
| side_10_i | input | 1 | Side status: 10 Mb/s link |
| side_100_i | input | 1 | Side status: 100 Mb/s link |
| side_fdx_i | input | 1 | Side status: full duplex |
| aneg_en_i | input | 1 | Auto-negotiation is enabled |
| link_state_o | output | 2 | 0 UNKNOWN, 1 DOWN, 2 UP |
| speed_o | output | 2 | 0 none, 1 10 Mb/s, 2 100 Mb/s |
| duplex_o | output | 2 | 0 unknown, 1 half, 2 full |
| change_pulse_o | output | 1 | One-cycle report of a change into or out of UP |
| reeval_req_o | output | 1 | Request another snapshot (state UNKNOWN) |
| up_count_o | output | CNT_W | Saturating count of reported moves into UP |
| drop_count_o | output | CNT_W | Saturating count of reported moves out of UP |

## Verification
The bench samples on both sides of the settle boundary, at elapsed 19 and 20 with a window of 20 cycles. An off-by-one in the since-change count would therefore go UP one sample early or late. It sends 0xFFFF, which has the link and auto-negotiation-complete bits set; a design that checked the invalid word after the other rules would pass it as a link. It drops the link bit while UP with an elapsed time of zero, where a design with the settle rule placed first would stall in UNKNOWN and report the drop late. It also flaps the status word between UNKNOWN and DOWN, breaks the side status while UP, and pushes the counters past their limit, so that wrong reporting, stale speed fields or wrapping counters each show up as a scoreboard mismatch.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // Bit positions inside the PHY basic status word
    localparam int LQ_LINK_BIT   = 2;
    localparam int LQ_ANDONE_BIT = 5;
    localparam logic [15:0] LQ_INVALID = 16'hFFFF;

    typedef enum logic [1:0] {
        LQ_UNKNOWN = 2'd0,
        LQ_DOWN    = 2'd1,
        LQ_UP      = 2'd2
    } lq_state_e;

    typedef enum logic [1:0] {
        LQ_SPD_NONE = 2'd0,
        LQ_SPD_10   = 2'd1,
        LQ_SPD_100  = 2'd2
    } lq_speed_e;

    typedef enum logic [1:0] {
        LQ_DPX_UNK  = 2'd0,
        LQ_DPX_HALF = 2'd1,
        LQ_DPX_FULL = 2'd2
    } lq_duplex_e;

    typedef struct packed {
        lq_state_e  state;
        lq_speed_e  speed;
        lq_duplex_e duplex;
        logic       pulse;
    } lq_link_t;

endpackage

// File: rtl/lq_status_tracker.sv
module lq_status_tracker #(
    parameter int SETTLE_CYC = 375_000_000,
    localparam int TW = $clog2(SETTLE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid_i,
    input  logic [15:0]   status_i,
    output logic [TW-1:0] elapsed_o
);

    localparam logic [TW-1:0] SAT = TW'(SETTLE_CYC);

    typedef struct packed {
        logic [15:0]   stored;
        logic [TW-1:0] tim;
    } trk_t;

    trk_t trk_d, trk_q;
    logic differs;

    always_comb begin
        differs = (status_i != trk_q.stored);
        trk_d   = trk_q;
        if (trk_q.tim != SAT) begin
            trk_d.tim = trk_q.tim + TW'(1);
        end
        if (sample_valid_i && differs) begin
            trk_d.stored = status_i;
            trk_d.tim    = TW'(1);
        end
        // A changed word has zero age on the sample that carries it
        elapsed_o = differs ? '0 : trk_q.tim;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R2: a differing sample is stored and its age restarts
    p_store_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && (status_i != trk_q.stored)) |=>
            ((trk_q.stored == $past(status_i)) && (trk_q.tim == TW'(1))));

    // R2: the age never passes the settle limit
    p_age_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.tim <= SAT);

endmodule

// File: rtl/lq_rule_eval.sv
module lq_rule_eval
    import lq_pkg::*;
#(
    parameter int SETTLE_CYC = 375_000_000,
    localparam int TW = $clog2(SETTLE_CYC + 1)
) (
    input  logic [15:0]   status_i,
    input  logic [TW-1:0] elapsed_i,
    input  lq_state_e     cur_i,
    input  logic          aneg_en_i,
    input  logic          side_link_i,
    input  logic          side_sig_i,
    input  logic          side_10_i,
    input  logic          side_100_i,
    output lq_state_e     cand_o
);

    lq_state_e raw;
    lq_state_e ruled;
    logic      side_ok;

    always_comb begin
        raw = status_i[LQ_LINK_BIT] ? LQ_UP : LQ_DOWN;

        // Ordered override list; first match wins
        if (status_i == LQ_INVALID) begin
            ruled = LQ_DOWN;
        end else if ((cur_i == LQ_UP) && (raw == LQ_DOWN)) begin
            ruled = LQ_DOWN;
        end else if (elapsed_i < TW'(SETTLE_CYC)) begin
            ruled = LQ_UNKNOWN;
        end else if (status_i[LQ_ANDONE_BIT]) begin
            ruled = raw;
        end else if (aneg_en_i) begin
            ruled = LQ_DOWN;
        end else begin
            ruled = raw;
        end

        // An UP verdict needs a consistent side status
        side_ok = side_link_i && side_sig_i && (side_10_i ^ side_100_i);
        cand_o  = ((ruled == LQ_UP) && !side_ok) ? LQ_UNKNOWN : ruled;
    end

endmodule

// File: rtl/lq_sat_counter.sv
module lq_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    // R11: a full counter stays full
    p_hold_at_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP));

    // R11: an event below the top adds exactly one
    p_step_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && (cnt_q != TOP)) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/link_qualifier.sv
module link_qualifier
    import lq_pkg::*;
#(
    parameter int SETTLE_CYC = 375_000_000,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid_i,
    input  logic [15:0]      status_i,
    input  logic             side_link_i,
    input  logic             side_sig_i,
    input  logic             side_10_i,
    input  logic             side_100_i,
    input  logic             side_fdx_i,
    input  logic             aneg_en_i,
    output logic [1:0]       link_state_o,
    output logic [1:0]       speed_o,
    output logic [1:0]       duplex_o,
    output logic             change_pulse_o,
    output logic             reeval_req_o,
    output logic [CNT_W-1:0] up_count_o,
    output logic [CNT_W-1:0] drop_count_o
);

    localparam int TW = $clog2(SETTLE_CYC + 1);

    logic [TW-1:0] elapsed;
    lq_state_e     cand;
    lq_link_t      link_d, link_q;
    logic          up_inc, drop_inc;

    lq_status_tracker #(.SETTLE_CYC(SETTLE_CYC)) u_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_valid_i (sample_valid_i),
        .status_i       (status_i),
        .elapsed_o      (elapsed)
    );

    lq_rule_eval #(.SETTLE_CYC(SETTLE_CYC)) u_rules (
        .status_i    (status_i),
        .elapsed_i   (elapsed),
        .cur_i       (link_q.state),
        .aneg_en_i   (aneg_en_i),
        .side_link_i (side_link_i),
        .side_sig_i  (side_sig_i),
        .side_10_i   (side_10_i),
        .side_100_i  (side_100_i),
        .cand_o      (cand)
    );

    always_comb begin
        link_d       = link_q;
        link_d.pulse = 1'b0;
        up_inc       = 1'b0;
        drop_inc     = 1'b0;
        if (sample_valid_i && (cand != link_q.state)) begin
            link_d.state = cand;
            if ((cand == LQ_UP) || (link_q.state == LQ_UP)) begin
                link_d.pulse = 1'b1;
                if (cand == LQ_UP) begin
                    link_d.speed  = side_100_i ? LQ_SPD_100 : LQ_SPD_10;
                    link_d.duplex = side_fdx_i ? LQ_DPX_FULL : LQ_DPX_HALF;
                    up_inc        = 1'b1;
                end else begin
                    link_d.speed  = LQ_SPD_NONE;
                    link_d.duplex = LQ_DPX_UNK;
                    drop_inc      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= '{state: LQ_UNKNOWN, speed: LQ_SPD_NONE,
                        duplex: LQ_DPX_UNK, pulse: 1'b0};
        end else begin
            link_q <= link_d;
        end
    end

    lq_sat_counter #(.W(CNT_W)) u_up_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (up_inc),
        .count_o (up_count_o)
    );

    lq_sat_counter #(.W(CNT_W)) u_drop_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (drop_inc),
        .count_o (drop_count_o)
    );

    assign link_state_o   = link_q.state;
    assign speed_o        = link_q.speed;
    assign duplex_o       = link_q.duplex;
    assign change_pulse_o = link_q.pulse;
    assign reeval_req_o   = (link_q.state == LQ_UNKNOWN);

    // R4: the all-ones word never leaves the link anywhere but DOWN
    p_invalid_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && (status_i == LQ_INVALID)) |=> (link_state_o == 2'd1));

    // R5: a lost link bit while UP is taken on that sample
    p_drop_at_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state_o == 2'd2) && sample_valid_i && !status_i[LQ_LINK_BIT])
            |=> (link_state_o == 2'd1));

    // R9: every pulse marks a real change that touches UP
    p_report_touches_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        change_pulse_o |-> ((link_state_o != $past(link_state_o)) &&
            ((link_state_o == 2'd2) || ($past(link_state_o) == 2'd2))));

    // R10: outside UP the speed and duplex fields are cleared
    p_fields_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state_o != 2'd2) |-> ((speed_o == 2'd0) && (duplex_o == 2'd0)));

    // R10: inside UP the fields carry a resolved value
    p_fields_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state_o == 2'd2) |-> ((speed_o != 2'd0) && (duplex_o != 2'd0)));

endmodule

// File: tb/link_qualifier_bench.sv
`timescale 1ns/1ps
module link_qualifier_bench;

    localparam int SETTLE = 20;
    localparam int CW     = 3;
    localparam int CMAX   = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic [15:0] status = 16'h0000;
    logic s_link = 1'b1, s_sig = 1'b1, s_10 = 1'b0, s_100 = 1'b1, s_fdx = 1'b1;
    logic aneg = 1'b1;

    logic [1:0] state_o, speed_o, dpx_o;
    logic pulse_o, reeval_o;
    logic [CW-1:0] up_o, drop_o;

    always #4 clk = ~clk;

    link_qualifier #(.SETTLE_CYC(SETTLE), .CNT_W(CW)) u_link_qualifier (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_valid_i (sample_valid),
        .status_i       (status),
        .side_link_i    (s_link),
        .side_sig_i     (s_sig),
        .side_10_i      (s_10),
        .side_100_i     (s_100),
        .side_fdx_i     (s_fdx),
        .aneg_en_i      (aneg),
        .link_state_o   (state_o),
        .speed_o        (speed_o),
        .duplex_o       (dpx_o),
        .change_pulse_o (pulse_o),
        .reeval_req_o   (reeval_o),
        .up_count_o     (up_o),
        .drop_count_o   (drop_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state
    logic [15:0] m_stored = 16'h0000;
    int m_chg = 0;
    int m_state = 0, m_speed = 0, m_dpx = 0, m_up = 0, m_drop = 0;

    // Scoreboard: {state, speed, duplex, pulse, reeval, up, drop}
    logic [14:0] exp_q[$];
    string tag_q[$];
    logic pend = 1'b0;

    always @(posedge clk) pend <= rst_n && sample_valid;

    function automatic logic [14:0] pack_act();
        return {state_o, speed_o, dpx_o, pulse_o, reeval_o, up_o, drop_o};
    endfunction

    always @(negedge clk) begin
        if (pend) begin
            logic [14:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pack_act() !== e) begin
                errors++;
                $display("FAIL %s actual %h expected %h", t, pack_act(), e);
            end
        end else if (rst_n) begin
            checks++;
            if (pulse_o !== 1'b0) begin
                errors++;
                $display("FAIL R9 idle pulse actual %b expected 0", pulse_o);
            end
        end
    end

    // Driver: called at a falling edge, sample taken at the next rising edge
    task automatic drive_now(input logic [15:0] st, input string tag);
        int edge_i, el, raw, nst, pul;
        logic ok;
        edge_i = cyc + 1;
        status = st;
        sample_valid = 1'b1;
        if (st != m_stored) begin
            m_stored = st;
            m_chg = edge_i;
            el = 0;
        end else begin
            el = edge_i - m_chg;
        end
        raw = st[2] ? 2 : 1;
        if (st == 16'hFFFF) nst = 1;
        else if (m_state == 2 && raw == 1) nst = 1;
        else if (el < SETTLE) nst = 0;
        else if (st[5]) nst = raw;
        else if (aneg) nst = 1;
        else nst = raw;
        ok = s_link && s_sig && (s_10 ^ s_100);
        if (nst == 2 && !ok) nst = 0;
        pul = 0;
        if (nst != m_state && (nst == 2 || m_state == 2)) begin
            pul = 1;
            if (nst == 2) begin
                m_speed = s_100 ? 2 : 1;
                m_dpx = s_fdx ? 2 : 1;
                if (m_up < CMAX) m_up++;
            end else begin
                m_speed = 0;
                m_dpx = 0;
                if (m_drop < CMAX) m_drop++;
            end
        end
        m_state = nst;
        exp_q.push_back({2'(m_state), 2'(m_speed), 2'(m_dpx), 1'(pul),
                         (m_state == 0), CW'(m_up), CW'(m_drop)});
        tag_q.push_back(tag);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic smp(input logic [15:0] st, input string tag);
        @(negedge clk);
        drive_now(st, tag);
    endtask

    // Sample an unchanged word once its age reaches the target
    task automatic smp_at(input logic [15:0] st, input int age, input string tag);
        @(negedge clk);
        while ((cyc + 1 - m_chg) < age) @(negedge clk);
        drive_now(st, tag);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", msg, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_chg = cyc + 1;
        @(negedge clk);
        // R1: reset values
        chk(8'(state_o), 8'd0, "R1 state");
        chk(8'(speed_o), 8'd0, "R1 speed");
        chk(8'(dpx_o), 8'd0, "R1 duplex");
        chk(8'(up_o), 8'd0, "R1 up count");
        chk(8'(drop_o), 8'd0, "R1 drop count");
        chk(8'(reeval_o), 8'd1, "R12 reeval at reset");

        smp(16'h0000, "R1");              // stored word is zero: young age, UNKNOWN
        smp_at(16'h0000, SETTLE, "R7");   // no AN done, AN on: DOWN, silent
        smp(16'h0024, "R2");              // change: age 0, UNKNOWN, silent
        smp_at(16'h0024, SETTLE - 1, "R6");
        smp_at(16'h0024, SETTLE, "R10");  // UP at 100 full
        s_10 = 1'b1; s_100 = 1'b0; s_fdx = 1'b0;
        smp(16'h0024, "R9");              // UP stays UP, fields kept
        s_10 = 1'b0; s_100 = 1'b1; s_fdx = 1'b1;
        smp(16'h0020, "R5");              // immediate drop
        smp(16'h0024, "R3");
        s_10 = 1'b1; s_100 = 1'b0; s_fdx = 1'b0;
        smp_at(16'h0024, SETTLE, "R3");   // UP at 10 half
        s_10 = 1'b0; s_100 = 1'b1; s_fdx = 1'b1;
        smp(16'hFFFF, "R4");
        smp_at(16'hFFFF, SETTLE + 5, "R4");
        smp(16'h0004, "R7");
        smp_at(16'h0004, SETTLE, "R7");   // AN enabled, not done: DOWN
        aneg = 1'b0;
        smp(16'h0004, "R7");              // AN off: raw UP
        s_sig = 1'b0;
        smp(16'h0004, "R8");              // UP lost to UNKNOWN, reported
        s_sig = 1'b1; s_10 = 1'b1;
        smp(16'h0004, "R8");              // both speeds set: UNKNOWN
        s_10 = 1'b0;
        smp(16'h0004, "R12");             // consistent again: UP
        aneg = 1'b1;
        smp(16'h0020, "R5");
        for (int i = 0; i < 4; i++) begin
            smp(16'h0024, "R6");
            smp(16'h0020, "R6");
        end
        smp(16'h0024, "R6");
        smp_at(16'h0024, SETTLE, "R6");   // flapping coalesced into one UP
        for (int i = 0; i < 6; i++) begin
            smp(16'h0020, "R11");
            smp(16'h0024, "R11");
            smp_at(16'h0024, SETTLE, "R11");
        end
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule